// File: doc/BRIEF.md
# Page-Write Byte Load Controller

This block is the write front end of a byte-wide nonvolatile memory model. It watches an asynchronous parallel bus made of an active-low chip select, an active-low write strobe, an address and a data byte. It gathers consecutive byte writes into a page buffer. No commit command exists. A sequence closes when the bus goes quiet for a load window, or when the next byte starts too late. The block then runs a programming interval of fixed length. When that interval ends, it presents the finished page to the array model in a single cycle as a page number, a byte-valid mask and the page data.

All bus inputs pass through a synchroniser before strobe edges are detected. Every time limit is a cycle-count parameter, so a bench can run the block with small values. A busy output, active low, is held low from the first accepted strobe until the commit. An active-low guard input aborts a sequence or a programming interval in progress. While the guard is low, all write strobes are ignored.

Top module: `pgw_loader`

## Requirements
- R1: After reset, `busy_n` is 1 and `cm_valid` is 0.
- R2: A write strobe is active while both `bus_ce_n` and `bus_we_n` are low. It starts when the later of the two falls and ends when the first of the two rises. Strobes driven by chip select and strobes driven by write enable behave the same.
- R3: The byte offset (`bus_addr[OFS_W-1:0]`, bits 5:0 by default) is taken when the strobe starts. The data byte is taken when the strobe ends. Changes on these buses at other times have no effect.
- R4: `cm_page` is `bus_addr[ADDR_W-1:OFS_W]` (bits 14:6 by default) at the first strobe of a sequence. The page bits of later strobes in the same sequence are ignored. `cm_page` stays constant while `busy_n` is low.
- R5: At commit, bit i of `cm_mask` is 1 exactly when offset i was loaded in this sequence. Byte i of `cm_data` is `cm_data[8*i+7:8*i]`, and it holds the last byte loaded at that offset. Between 1 and 64 offsets can be loaded. Positions that were not loaded have mask bit 0.
- R6: `busy_n` goes low right after rising clock edge SYNC_STAGES+1, counting the first edge after the strobe starts as edge 1. It stays low until the commit.
- R7: If no strobe follows, `cm_valid` is high right after rising edge SYNC_STAGES+LOAD_WIN+PROG_LEN, counting the first edge after the last strobe ends as edge 1.
- R8: A strobe that starts more than BLC_CYC cycles after the previous accepted start closes the sequence and starts programming at once. That byte is not loaded.
- R9: Strobes during the programming interval are ignored. They change neither the committed mask nor the committed data. The mask is constant throughout programming.
- R10: While the synchronised `guard_n` is low, the block returns to idle and `busy_n` is 1. Any pending page is dropped without a commit, and strobes are ignored. A later sequence commits only its own bytes.
- R11: `cm_valid` is a single-cycle pulse. It is high in the same cycle in which `busy_n` returns to 1. Apart from a guard abort, it is the only reason `busy_n` returns to 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_ce_n | input | 1 | Active-low chip select, asynchronous |
| bus_we_n | input | 1 | Active-low write enable, asynchronous |
| bus_addr | input | ADDR_W | Byte address: page in upper bits, offset in low OFS_W bits |
| bus_din | input | DATA_W | Write data byte |
| guard_n | input | 1 | Active-low guard: aborts and blocks writes while low |
| busy_n | output | 1 | Low from first accepted strobe until commit or abort |
| cm_valid | output | 1 | One-cycle commit pulse |
| cm_page | output | ADDR_W-OFS_W | Page number of the committed sequence |
| cm_mask | output | 2**OFS_W | One bit per loaded byte position |
| cm_data | output | DATA_W*2**OFS_W | Page buffer contents, byte i at bits 8i+7:8i |

## Verification
The checker observes on every cycle that the commit pulse lasts one cycle and coincides with the release of busy. It also observes that busy returns to 1 only through a commit or a guard abort, that a low guard forces idle with no commit, and that a committed mask is never empty. It further checks that the page number and the mask hold still while programming is under way. Only the bench scenarios can show the following: which offset and which data byte are taken at the strobe edges, the exact latencies of busy and commit, that a late strobe closes the sequence and is dropped, and that bytes written during programming or under a low guard never reach a commit.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_PROG = 2'd2
  } pgw_state_e;
endpackage

// File: rtl/pgw_sync.sv
module pgw_sync #(
  parameter int              W       = 1,
  parameter int              STAGES  = 2,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[g] <= RST_VAL;
        else        chain[g] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[g] <= RST_VAL;
        else        chain[g] <= chain[g-1];
      end
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/pgw_ctr.sv
module pgw_ctr #(
  parameter int MAX = 4,
  parameter int CW  = $clog2(MAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  output logic [CW-1:0] cnt
);
  logic [CW-1:0] cnt_nx;

  always_comb begin
    if (clr)                    cnt_nx = '0;
    else if (cnt != CW'(MAX))   cnt_nx = cnt + 1'b1;
    else                        cnt_nx = cnt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_nx;
  end
endmodule

// File: rtl/pgw_pagebuf.sv
module pgw_pagebuf #(
  parameter int OFS_W  = 6,
  parameter int DATA_W = 8,
  parameter int NB     = 1 << OFS_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 wr,
  input  logic [OFS_W-1:0]     wr_ofs,
  input  logic [DATA_W-1:0]    wr_data,
  output logic [NB-1:0]        mask,
  output logic [NB*DATA_W-1:0] data
);
  logic [DATA_W-1:0] byte_q [NB];

  for (genvar g = 0; g < NB; g++) begin : g_byte
    logic hit;
    assign hit = wr && (wr_ofs == OFS_W'(g));

    always_ff @(posedge clk) begin
      if (hit) byte_q[g] <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   mask[g] <= 1'b0;
      else if (clr) mask[g] <= 1'b0;
      else if (hit) mask[g] <= 1'b1;
    end

    assign data[g*DATA_W +: DATA_W] = byte_q[g];
  end
endmodule

// File: rtl/pgw_loader.sv
module pgw_loader
  import pgw_pkg::*;
#(
  parameter int ADDR_W      = 15,
  parameter int OFS_W       = 6,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int BLC_CYC     = 3750,
  parameter int LOAD_WIN    = 12500,
  parameter int PROG_LEN    = 1250000
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 bus_ce_n,
  input  logic                                 bus_we_n,
  input  logic [ADDR_W-1:0]                    bus_addr,
  input  logic [DATA_W-1:0]                    bus_din,
  input  logic                                 guard_n,
  output logic                                 busy_n,
  output logic                                 cm_valid,
  output logic [ADDR_W-OFS_W-1:0]              cm_page,
  output logic [(1<<OFS_W)-1:0]                cm_mask,
  output logic [DATA_W*(1<<OFS_W)-1:0]         cm_data
);
  localparam int PAGE_W = ADDR_W - OFS_W;
  localparam int NB     = 1 << OFS_W;
  localparam int BLC_W  = $clog2(BLC_CYC + 1);
  localparam int WIN_W  = $clog2(LOAD_WIN + 1);
  localparam int PRG_W  = $clog2(PROG_LEN + 1);

  // reset release synchroniser
  logic rst_q;
  pgw_sync #(.W(1), .STAGES(2), .RST_VAL(1'b0)) u_rsync (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_q)
  );

  // bus control synchroniser: {guard, ce, we}
  logic [2:0] ctl_s;
  pgw_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b011)) u_csync (
    .clk(clk), .rst_n(rst_q), .d({guard_n, bus_ce_n, bus_we_n}), .q(ctl_s)
  );

  logic guard_s, stb, stb_d, fall_ok, rise_ok;
  assign guard_s = ctl_s[2];
  assign stb     = ~ctl_s[1] & ~ctl_s[0];
  assign fall_ok = stb & ~stb_d & guard_s;
  assign rise_ok = ~stb & stb_d & guard_s;

  pgw_state_e state, state_nx;
  logic buf_clr, buf_wr, cap_page, cap_ofs, blc_clr, prog_done;
  logic [BLC_W-1:0] blc_cnt;
  logic [WIN_W-1:0] idle_cnt;
  logic [PRG_W-1:0] prog_cnt;
  logic [PAGE_W-1:0] page_q;
  logic [OFS_W-1:0]  ofs_q;
  logic blc_late, win_done, prog_end;

  assign blc_late = (blc_cnt == BLC_W'(BLC_CYC));
  assign win_done = (idle_cnt == WIN_W'(LOAD_WIN - 1));
  assign prog_end = (prog_cnt == PRG_W'(PROG_LEN - 1));

  // next-state logic
  always_comb begin
    state_nx  = state;
    buf_clr   = 1'b0;
    buf_wr    = 1'b0;
    cap_page  = 1'b0;
    cap_ofs   = 1'b0;
    blc_clr   = 1'b0;
    prog_done = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (fall_ok) begin
          state_nx = ST_LOAD;
          buf_clr  = 1'b1;
          cap_page = 1'b1;
          cap_ofs  = 1'b1;
          blc_clr  = 1'b1;
        end
      end
      ST_LOAD: begin
        if (fall_ok && blc_late) begin
          state_nx = ST_PROG;
        end else if (fall_ok) begin
          cap_ofs = 1'b1;
          blc_clr = 1'b1;
        end
        if (rise_ok) buf_wr = 1'b1;
        if (!stb && win_done) state_nx = ST_PROG;
      end
      ST_PROG: begin
        if (prog_end) begin
          state_nx  = ST_IDLE;
          prog_done = 1'b1;
        end
      end
      default: state_nx = ST_IDLE;
    endcase
    if (!guard_s) begin
      state_nx  = ST_IDLE;
      buf_clr   = 1'b1;
      buf_wr    = 1'b0;
      prog_done = 1'b0;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      state    <= ST_IDLE;
      stb_d    <= 1'b0;
      cm_valid <= 1'b0;
      page_q   <= '0;
      ofs_q    <= '0;
    end else begin
      state    <= state_nx;
      stb_d    <= stb;
      cm_valid <= prog_done;
      if (cap_page) page_q <= bus_addr[ADDR_W-1:OFS_W];
      if (cap_ofs)  ofs_q  <= bus_addr[OFS_W-1:0];
    end
  end

  // timers
  pgw_ctr #(.MAX(BLC_CYC), .CW(BLC_W)) u_blc (
    .clk(clk), .rst_n(rst_q), .clr(blc_clr || state != ST_LOAD), .cnt(blc_cnt)
  );
  pgw_ctr #(.MAX(LOAD_WIN), .CW(WIN_W)) u_win (
    .clk(clk), .rst_n(rst_q), .clr(stb || state != ST_LOAD), .cnt(idle_cnt)
  );
  pgw_ctr #(.MAX(PROG_LEN), .CW(PRG_W)) u_prg (
    .clk(clk), .rst_n(rst_q), .clr(state != ST_PROG), .cnt(prog_cnt)
  );

  pgw_pagebuf #(.OFS_W(OFS_W), .DATA_W(DATA_W), .NB(NB)) u_buf (
    .clk(clk), .rst_n(rst_q), .clr(buf_clr), .wr(buf_wr),
    .wr_ofs(ofs_q), .wr_data(bus_din), .mask(cm_mask), .data(cm_data)
  );

  assign busy_n  = (state == ST_IDLE);
  assign cm_page = page_q;
endmodule

// File: rtl/pgw_loader_chk.sv
module pgw_loader_chk #(
  parameter int PAGE_W = 9,
  parameter int NB     = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy_n,
  input logic              cm_valid,
  input logic [PAGE_W-1:0] cm_page,
  input logic [NB-1:0]     cm_mask,
  input logic              guard_s,
  input logic              in_prog
);
  // R11
  commit_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cm_valid |-> busy_n);

  // R11
  commit_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cm_valid |=> !cm_valid);

  // R11
  release_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy_n) && $past(guard_s)) |-> cm_valid);

  // R10
  guard_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !guard_s |=> (busy_n && !cm_valid));

  // R4
  page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_n && $past(!busy_n)) |-> $stable(cm_page));

  // R9
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_prog && $past(in_prog)) |-> $stable(cm_mask));

  // R5
  mask_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cm_valid |-> ($countones(cm_mask) >= 1));
endmodule

bind pgw_loader pgw_loader_chk #(.PAGE_W(ADDR_W - OFS_W), .NB(1 << OFS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy_n(busy_n), .cm_valid(cm_valid),
  .cm_page(cm_page), .cm_mask(cm_mask), .guard_s(guard_s),
  .in_prog(state == pgw_pkg::ST_PROG)
);

// File: tb/sim_pgw_loader.sv
`timescale 1ns/1ps
module sim_pgw_loader;
  localparam int SYNC = 2;
  localparam int BLC  = 16;
  localparam int WIN  = 40;
  localparam int PRG  = 30;
  localparam int NB   = 64;

  logic clk = 1'b0;
  logic rst_n;
  logic bus_ce_n, bus_we_n, guard_n;
  logic [14:0] bus_addr;
  logic [7:0]  bus_din;
  logic busy_n, cm_valid;
  logic [8:0]  cm_page;
  logic [NB-1:0] cm_mask;
  logic [NB*8-1:0] cm_data;

  int n_run = 0, n_fail = 0;
  logic [8:0]    exp_page;
  logic [NB-1:0] exp_mask;
  logic [7:0]    exp_data [NB];

  always #4 clk = ~clk;

  pgw_loader #(.SYNC_STAGES(SYNC), .BLC_CYC(BLC), .LOAD_WIN(WIN), .PROG_LEN(PRG)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_ce_n(bus_ce_n), .bus_we_n(bus_we_n),
    .bus_addr(bus_addr), .bus_din(bus_din), .guard_n(guard_n),
    .busy_n(busy_n), .cm_valid(cm_valid), .cm_page(cm_page),
    .cm_mask(cm_mask), .cm_data(cm_data)
  );

  function automatic logic [8:0] f_page(input logic [14:0] a); return a[14:6]; endfunction
  function automatic logic [5:0] f_ofs(input logic [14:0] a);  return a[5:0];  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n); repeat (n) @(negedge clk); endtask

  task automatic exp_clear(input logic [14:0] first_addr);
    exp_page = f_page(first_addr);
    exp_mask = '0;
  endtask

  task automatic exp_load(input logic [14:0] a, input logic [7:0] d);
    exp_mask[f_ofs(a)] = 1'b1;
    exp_data[f_ofs(a)] = d;
  endtask

  // strobe: offset must be taken at start, data at end (R2, R3)
  task automatic do_strobe(input logic [14:0] a, input logic [7:0] d, input bit by_ce);
    @(negedge clk);
    bus_addr = a; bus_din = ~d;
    if (by_ce) begin bus_we_n = 1'b0; @(negedge clk); bus_ce_n = 1'b0; end
    else       begin bus_ce_n = 1'b0; @(negedge clk); bus_we_n = 1'b0; end
    idle(4);
    bus_addr = ~a; bus_din = d;
    idle(3);
    bus_ce_n = 1'b1; bus_we_n = 1'b1;
  endtask

  task automatic wait_commit(input int limit, output bit seen, output int n, output bit early_rel);
    seen = 1'b0; n = 0; early_rel = 1'b0;
    while (n < limit && !seen) begin
      @(posedge clk); n++;
      @(negedge clk);
      if (cm_valid) seen = 1'b1;
      else if (busy_n) early_rel = 1'b1;
    end
  endtask

  task automatic check_commit(input string tag);
    bit seen, er; int n, bad;
    wait_commit(300, seen, n, er);
    chk(seen, {tag, " commit seen"}, 64'(seen), 64'd1);
    chk(cm_page == exp_page, {tag, " R4 page"}, 64'(cm_page), 64'(exp_page));
    chk(cm_mask == exp_mask, {tag, " R5 mask"}, cm_mask, exp_mask);
    bad = -1;
    for (int i = 0; i < NB; i++)
      if (exp_mask[i] && cm_data[i*8 +: 8] !== exp_data[i] && bad < 0) bad = i;
    chk(bad < 0, {tag, " R3 data"}, (bad < 0) ? 64'd0 : 64'(cm_data[bad*8 +: 8]),
        (bad < 0) ? 64'd0 : 64'(exp_data[bad]));
    @(negedge clk);
    // R11 pulse lasts one cycle
    chk(!cm_valid && busy_n, {tag, " R11 pulse"}, 64'({cm_valid, busy_n}), 64'b01);
  endtask

  task automatic summary;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    bit seen, er; int n;
    logic [14:0] a, a0;
    logic [7:0]  d;
    int nb;
    void'($urandom(32'd7319));
    rst_n = 1'b0; bus_ce_n = 1'b1; bus_we_n = 1'b1; guard_n = 1'b1;
    bus_addr = '0; bus_din = '0;
    idle(5);
    rst_n = 1'b1;
    idle(6);
    // R1 reset state
    chk(busy_n === 1'b1 && cm_valid === 1'b0, "R1 reset", 64'({busy_n, cm_valid}), 64'b10);

    // R6 busy latency and R7 commit latency, single byte
    a = {9'h0A3, 6'd17}; d = 8'h5C;
    exp_clear(a); exp_load(a, d);
    @(negedge clk);
    bus_addr = a; bus_din = d; bus_ce_n = 1'b0; bus_we_n = 1'b0;
    idle(SYNC);
    chk(busy_n == 1'b1, "R6 busy before", 64'(busy_n), 64'd1);
    idle(1);
    chk(busy_n == 1'b0, "R6 busy low", 64'(busy_n), 64'd0);
    idle(5);
    bus_ce_n = 1'b1; bus_we_n = 1'b1;
    wait_commit(300, seen, n, er);
    chk(seen && n == SYNC + WIN + PRG, "R7 latency", 64'(n), 64'(SYNC + WIN + PRG));
    chk(!er, "R6 busy held", 64'(er), 64'd0);
    chk(cm_mask == exp_mask && cm_data[17*8 +: 8] == d, "R5 single", cm_mask, exp_mask);
    idle(4);

    // R2 chip-select driven strobe, R3 edge capture
    a = {9'h055, 6'd2}; exp_clear(a);
    do_strobe(a, 8'hA1, 1'b1); exp_load(a, 8'hA1); idle(4);
    a = {9'h055, 6'd40};
    do_strobe(a, 8'h3E, 1'b0); exp_load(a, 8'h3E);
    check_commit("R2 ce/we");
    idle(4);

    // R4 later page bits ignored, R5 repeated offset keeps last byte
    a0 = {9'h1F0, 6'd5}; exp_clear(a0);
    do_strobe(a0, 8'h11, 1'b0); exp_load(a0, 8'h11); idle(4);
    a = {9'h002, 6'd7};
    do_strobe(a, 8'h77, 1'b0); exp_load(a, 8'h77); idle(4);
    a = {9'h0C1, 6'd5};
    do_strobe(a, 8'h22, 1'b1); exp_load(a, 8'h22);
    check_commit("R4 page");
    idle(4);

    // R5 full 64-byte page
    exp_clear({9'h1A5, 6'd0});
    for (int i = 0; i < NB; i++) begin
      a = {9'h1A5, 6'(i)}; d = 8'(i * 3 + 1);
      do_strobe(a, d, i[0]); exp_load(a, d); idle(4);
    end
    check_commit("R5 full");
    idle(4);

    // R8 late strobe closes the sequence and is dropped
    a = {9'h033, 6'd10}; exp_clear(a);
    do_strobe(a, 8'hC3, 1'b0); exp_load(a, 8'hC3);
    idle(22);
    do_strobe({9'h033, 6'd11}, 8'h99, 1'b0);
    check_commit("R8 late");
    idle(4);

    // R9 strobe during programming ignored
    a = {9'h0F0, 6'd3}; exp_clear(a);
    do_strobe(a, 8'h4D, 1'b0); exp_load(a, 8'h4D);
    idle(SYNC + WIN + 5);
    do_strobe({9'h0F0, 6'd4}, 8'hEE, 1'b0);
    check_commit("R9 prog");
    idle(10);
    chk(busy_n == 1'b1, "R9 no new seq", 64'(busy_n), 64'd1);

    // R10 guard abort during programming
    do_strobe({9'h111, 6'd9}, 8'h12, 1'b0);
    idle(SYNC + WIN + 5);
    guard_n = 1'b0;
    idle(SYNC + 1);
    chk(busy_n == 1'b1, "R10 abort busy", 64'(busy_n), 64'd1);
    wait_commit(PRG + 40, seen, n, er);
    chk(!seen, "R10 no commit", 64'(seen), 64'd0);
    guard_n = 1'b1; idle(4);

    // R10 strobes ignored while guard low
    guard_n = 1'b0; idle(4);
    do_strobe({9'h122, 6'd1}, 8'h34, 1'b0);
    chk(busy_n == 1'b1, "R10 blocked busy", 64'(busy_n), 64'd1);
    idle(4); guard_n = 1'b1; idle(4);
    wait_commit(WIN + PRG + 20, seen, n, er);
    chk(!seen && busy_n, "R10 blocked commit", 64'(seen), 64'd0);

    // R10 next sequence commits only its own bytes
    a = {9'h111, 6'd20}; exp_clear(a);
    do_strobe(a, 8'h6B, 1'b0); exp_load(a, 8'h6B);
    check_commit("R10 fresh");
    idle(4);

    // random sequences (R3, R4, R5)
    for (int it = 0; it < 16; it++) begin
      nb = 1 + int'($urandom % 10);
      a0 = 15'($urandom);
      exp_clear(a0);
      for (int k = 0; k < nb; k++) begin
        a = (k == 0) ? a0 : 15'($urandom);
        d = 8'($urandom);
        do_strobe(a, d, 1'($urandom));
        exp_load(a, d);
        idle(4);
      end
      check_commit("R5 random");
      idle(4);
    end

    summary();
  end
endmodule